// File: doc/BRIEF.md
# Shared-Bank Atomic Unit with Broadcast Update

This unit sits beside a shared cache bank, the point where all clusters agree on memory contents. It executes read-modify-write atomics for any requester. Because the whole operation happens at the bank, the result is atomic with respect to every other global or atomic access. Requests arrive on a single channel that carries an opcode, a word address, an operand and a source tag. The unit accepts one request per cycle and overlaps successive operations in a two-stage pipeline: the first stage reads the word and the second computes and writes it back. When two operations on the same word follow each other, the second one receives the first one's result through a forwarding path. Every operation returns the value the word held before it was changed, together with the source tag of the request.

A broadcast-update operation writes its operand into the bank word. It then places the address and the new value into a fan-out stage that copies the message to every cluster port. Clusters use this to refresh their cached copy, so cores can spin on a local copy. One example is a sense-reversal barrier, where the last core to arrive publishes the flipped sense. Each port has its own valid/ready handshake. A message stays on a port until that port accepts it. If a second broadcast arrives while any port still holds the first one, the pipeline stalls.

Top module: `atomic_bcast_unit`

## Requirements
- R1: After reset every bank word is zero, `req_ready_o` is high, and both `rsp_valid_o` and all bits of `bc_valid_o` are low.
- R2: Opcode 0 (add) stores old + operand, with 32-bit two's-complement wraparound, and responds with the old value.
- R3: Opcode 1 (increment) stores old + 1 and opcode 2 (decrement) stores old - 1, both wrapping at 32 bits, and both respond with the old value.
- R4: Opcode 3 (exchange) stores the operand and responds with the old value.
- R5: A request is accepted on any cycle where `req_valid_i` and `req_ready_o` are both high. When there is no stall, its response is valid exactly two rising edges after the accepting edge, carries the request's source tag, and responses come back in request order.
- R6: Back-to-back requests to the same address see each other's results: no update is lost, and each response equals the value left by the request before it.
- R7: Opcode 4 (broadcast update) stores the operand and responds with the old value. On the following edge, all ports raise their valid together and present the address and the new value. The bank write takes effect no later than the notification.
- R8: A port's valid stays high, with address and data unchanged, until that port's ready is sampled high. Each port clears independently of the others.
- R9: A broadcast that reaches the result stage while any port still has a message pending holds the pipeline. During the hold, `req_ready_o` is low and `rsp_valid_o` is low. Operation resumes once every port has drained, and `req_ready_o` is never low while all ports are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_op_i | input | 3 | Opcode: 0 add, 1 increment, 2 decrement, 3 exchange, 4 broadcast update |
| req_addr_i | input | ADDR_W | Word address in the bank |
| req_data_i | input | DATA_W | Operand |
| req_src_i | input | SRC_W | Source tag, returned with the response |
| rsp_valid_o | output | 1 | Response valid |
| rsp_data_o | output | DATA_W | Word value before the operation |
| rsp_src_o | output | SRC_W | Source tag of the request being answered |
| bc_valid_o | output | N_PORTS | Per-port broadcast valid |
| bc_ready_i | input | N_PORTS | Per-port broadcast ready |
| bc_addr_o | output | ADDR_W | Broadcast word address, shared by all ports |
| bc_data_o | output | DATA_W | Broadcast word value, shared by all ports |

## Verification
The bench builds the unit with its default parameters: 32-bit words, 16 bank words, a 4-bit source tag and four broadcast ports. The small bank lets a short vector table return to the same words many times. It mixes back-to-back same-address operations, operations to the same word separated by one or two others, and wraparound at both ends of the 32-bit range. Four ports are enough to release one port while the others still hold a message, and to hold a second broadcast in the stall until the last port drains.

// File: rtl/atomic_bcast_pkg.sv
package atomic_bcast_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_INC   = 3'd1,
    OP_DEC   = 3'd2,
    OP_XCHG  = 3'd3,
    OP_BCAST = 3'd4
  } amo_op_e;
endpackage

// File: rtl/atomic_alu.sv
module atomic_alu
  import atomic_bcast_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  amo_op_e             op_i,
  input  logic [DATA_W-1:0]   old_i,
  input  logic [DATA_W-1:0]   operand_i,
  output logic [DATA_W-1:0]   new_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    unique case (op_i)
      OP_ADD:   new_o = old_i + operand_i;
      OP_INC:   new_o = old_i + ONE;
      OP_DEC:   new_o = old_i - ONE;
      OP_XCHG,
      OP_BCAST: new_o = operand_i;
      default:  new_o = old_i;
    endcase
  end
endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/bcast_fanout.sv
module bcast_fanout #(
  parameter int N_PORTS = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               busy_o,
  output logic [N_PORTS-1:0] port_valid_o,
  input  logic [N_PORTS-1:0] port_ready_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [DATA_W-1:0]  data_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (launch_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  // One pending flag per destination; each copy retires on its own handshake
  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    logic pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                pend_q <= 1'b0;
      else if (launch_i)          pend_q <= 1'b1;
      else if (port_ready_i[p])   pend_q <= 1'b0;
    end
    assign port_valid_o[p] = pend_q;
  end

  assign busy_o = |port_valid_o;
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/atomic_bcast_unit.sv
module atomic_bcast_unit
  import atomic_bcast_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int SRC_W   = 4,
  parameter int N_PORTS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [2:0]         req_op_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_data_i,
  input  logic [SRC_W-1:0]   req_src_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_data_o,
  output logic [SRC_W-1:0]   rsp_src_o,
  output logic [N_PORTS-1:0] bc_valid_o,
  input  logic [N_PORTS-1:0] bc_ready_i,
  output logic [ADDR_W-1:0]  bc_addr_o,
  output logic [DATA_W-1:0]  bc_data_o
);
  // Stage 1: accepted request, bank read
  logic              s1_valid_q;
  amo_op_e           s1_op_q;
  logic [ADDR_W-1:0] s1_addr_q;
  logic [DATA_W-1:0] s1_data_q;
  logic [SRC_W-1:0]  s1_src_q;
  // Stage 2: compute, write back, respond
  logic              s2_valid_q;
  amo_op_e           s2_op_q;
  logic [ADDR_W-1:0] s2_addr_q;
  logic [DATA_W-1:0] s2_data_q;
  logic [SRC_W-1:0]  s2_src_q;
  logic [DATA_W-1:0] s2_old_q;

  logic [DATA_W-1:0] s2_new;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] s1_old;
  logic              bc_busy;
  logic              stall;
  logic              advance;
  logic              accept;
  logic              launch;

  assign stall   = s2_valid_q && (s2_op_q == OP_BCAST) && bc_busy;
  assign advance = !stall;
  assign accept  = req_valid_i && advance;
  assign launch  = s2_valid_q && (s2_op_q == OP_BCAST) && advance;

  // Forward the result being written this edge to a same-address follower
  assign s1_old = (s2_valid_q && (s2_addr_q == s1_addr_q)) ? s2_new : mem_rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_op_q    <= OP_ADD;
      s1_addr_q  <= '0;
      s1_data_q  <= '0;
      s1_src_q   <= '0;
      s2_valid_q <= 1'b0;
      s2_op_q    <= OP_ADD;
      s2_addr_q  <= '0;
      s2_data_q  <= '0;
      s2_src_q   <= '0;
      s2_old_q   <= '0;
    end else if (advance) begin
      s1_valid_q <= accept;
      s1_op_q    <= amo_op_e'(req_op_i);
      s1_addr_q  <= req_addr_i;
      s1_data_q  <= req_data_i;
      s1_src_q   <= req_src_i;
      s2_valid_q <= s1_valid_q;
      s2_op_q    <= s1_op_q;
      s2_addr_q  <= s1_addr_q;
      s2_data_q  <= s1_data_q;
      s2_src_q   <= s1_src_q;
      s2_old_q   <= s1_old;
    end
  end

  atomic_alu #(.DATA_W(DATA_W)) i_alu (
    .op_i      (s2_op_q),
    .old_i     (s2_old_q),
    .operand_i (s2_data_q),
    .new_o     (s2_new)
  );

  word_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (s2_valid_q && advance),
    .waddr_i (s2_addr_q),
    .wdata_i (s2_new),
    .raddr_i (s1_addr_q),
    .rdata_o (mem_rdata)
  );

  bcast_fanout #(.N_PORTS(N_PORTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_fanout (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_i     (launch),
    .addr_i       (s2_addr_q),
    .data_i       (s2_new),
    .busy_o       (bc_busy),
    .port_valid_o (bc_valid_o),
    .port_ready_i (bc_ready_i),
    .addr_o       (bc_addr_o),
    .data_o       (bc_data_o)
  );

  assign req_ready_o = advance;
  assign rsp_valid_o = s2_valid_q && advance;
  assign rsp_data_o  = s2_old_q;
  assign rsp_src_o   = s2_src_q;
endmodule

// File: rtl/atomic_bcast_unit_chk.sv
module atomic_bcast_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int N_PORTS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_ready_o,
  input logic               rsp_valid_o,
  input logic [N_PORTS-1:0] bc_valid_o,
  input logic [N_PORTS-1:0] bc_ready_i,
  input logic [ADDR_W-1:0]  bc_addr_o,
  input logic [DATA_W-1:0]  bc_data_o
);
  AST_BC_PORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(bc_valid_o & ~bc_ready_i)) |=>
      ((bc_valid_o & $past(bc_valid_o & ~bc_ready_i)) == $past(bc_valid_o & ~bc_ready_i))); // R8

  AST_BC_MSG_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(bc_valid_o & ~bc_ready_i)) |=> ($stable(bc_addr_o) && $stable(bc_data_o))); // R8

  AST_BC_ALL_PORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(bc_valid_o) == '0) && (bc_valid_o != '0)) |-> (&bc_valid_o)); // R7

  AST_STALL_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> (|bc_valid_o)); // R9

  AST_NO_RSP_IN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> !rsp_valid_o); // R9
endmodule

bind atomic_bcast_unit atomic_bcast_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_PORTS(N_PORTS)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .bc_valid_o  (bc_valid_o),
  .bc_ready_i  (bc_ready_i),
  .bc_addr_o   (bc_addr_o),
  .bc_data_o   (bc_data_o)
);

// File: tb/test_atomic_bcast_unit.sv
module test_atomic_bcast_unit;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int SRC_W   = 4;
  localparam int N_PORTS = 4;
  localparam int NVEC    = 12;

  // {op[2:0], addr[3:0], operand[31:0], expected old[31:0]}
  localparam logic [70:0] VEC [NVEC] = '{
    {3'd0, 4'd1, 32'd5,          32'd0},          // R2
    {3'd1, 4'd1, 32'd0,          32'd5},          // R3 R6
    {3'd2, 4'd1, 32'd0,          32'd6},          // R3 R6
    {3'd3, 4'd1, 32'd100,        32'd5},          // R4 R6
    {3'd0, 4'd2, 32'hFFFF_FFFF,  32'd0},          // R2
    {3'd1, 4'd2, 32'd0,          32'hFFFF_FFFF},  // R3 wrap up
    {3'd2, 4'd2, 32'd0,          32'd0},          // R3 wrap down
    {3'd0, 4'd1, 32'd0,          32'd100},        // R6 gap
    {3'd0, 4'd3, 32'd7,          32'd0},
    {3'd0, 4'd1, 32'd1,          32'd100},
    {3'd0, 4'd3, 32'd1,          32'd7},
    {3'd3, 4'd2, 32'd3,          32'hFFFF_FFFF}   // R4
  };

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               req_valid_i = 1'b0;
  logic               req_ready_o;
  logic [2:0]         req_op_i = '0;
  logic [ADDR_W-1:0]  req_addr_i = '0;
  logic [DATA_W-1:0]  req_data_i = '0;
  logic [SRC_W-1:0]   req_src_i = '0;
  logic               rsp_valid_o;
  logic [DATA_W-1:0]  rsp_data_o;
  logic [SRC_W-1:0]   rsp_src_o;
  logic [N_PORTS-1:0] bc_valid_o;
  logic [N_PORTS-1:0] bc_ready_i = '0;
  logic [ADDR_W-1:0]  bc_addr_o;
  logic [DATA_W-1:0]  bc_data_o;

  int checks = 0;
  int errors = 0;
  int mon_idx = 0;
  logic mon_on = 1'b0;

  always #4 clk_i = ~clk_i;

  atomic_bcast_unit #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_W(SRC_W), .N_PORTS(N_PORTS)
  ) i_atomic_bcast_unit (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_op_i, .req_addr_i,
    .req_data_i, .req_src_i, .rsp_valid_o, .rsp_data_o, .rsp_src_o,
    .bc_valid_o, .bc_ready_i, .bc_addr_o, .bc_data_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input logic [SRC_W-1:0] s);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = op; req_addr_i = a; req_data_i = d; req_src_i = s;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  // Response monitor for the table walk (R5 ordering and tags)
  always @(negedge clk_i) begin
    if (mon_on && rsp_valid_o) begin
      if (mon_idx < NVEC) begin
        chk(rsp_data_o == VEC[mon_idx][31:0], "R2/R3/R4/R6 old value", rsp_data_o, VEC[mon_idx][31:0]);
        chk(rsp_src_o == SRC_W'(mon_idx), "R5 source tag order", 32'(rsp_src_o), 32'(mon_idx));
      end else begin
        chk(1'b0, "R5 extra response", 32'(mon_idx), 32'(NVEC));
      end
      mon_idx++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1 ready after reset", 32'(req_ready_o), 32'd1);
    chk(rsp_valid_o == 1'b0, "R1 no response after reset", 32'(rsp_valid_o), 32'd0);
    chk(bc_valid_o == '0, "R1 no broadcast after reset", 32'(bc_valid_o), 32'd0);

    // Table walk, one request per cycle
    bc_ready_i = '1;
    mon_on = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      req_valid_i = 1'b1;
      req_op_i    = VEC[i][70:68];
      req_addr_i  = VEC[i][67:64];
      req_data_i  = VEC[i][63:32];
      req_src_i   = SRC_W'(i);
      @(negedge clk_i);
    end
    req_valid_i = 1'b0;
    repeat (4) @(negedge clk_i);
    mon_on = 1'b0;
    chk(mon_idx == NVEC, "R5 response count", 32'(mon_idx), 32'(NVEC));

    // R5 latency and readback of final values
    issue(3'd0, 4'd1, 32'd0, 4'd9);
    chk(rsp_valid_o == 1'b0, "R5 no response one edge after accept", 32'(rsp_valid_o), 32'd0);
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b1, "R5 response two edges after accept", 32'(rsp_valid_o), 32'd1);
    chk(rsp_data_o == 32'd101, "R2 final word 1", rsp_data_o, 32'd101);
    chk(rsp_src_o == 4'd9, "R5 tag", 32'(rsp_src_o), 32'd9);

    // Broadcast update with ports blocked
    bc_ready_i = '0;
    issue(3'd4, 4'd5, 32'h0000_00A5, 4'd1);
    @(negedge clk_i);
    chk(rsp_valid_o && rsp_data_o == 32'd0, "R7 broadcast old value", rsp_data_o, 32'd0);
    @(negedge clk_i);
    chk(bc_valid_o == 4'hF, "R7 all ports valid", 32'(bc_valid_o), 32'hF);
    chk(bc_addr_o == 4'd5 && bc_data_o == 32'hA5, "R7 broadcast message", bc_data_o, 32'hA5);

    issue(3'd4, 4'd6, 32'd1, 4'd2);
    @(negedge clk_i);
    chk(req_ready_o == 1'b0, "R9 stall while ports pending", 32'(req_ready_o), 32'd0);
    chk(rsp_valid_o == 1'b0, "R9 no response in stall", 32'(rsp_valid_o), 32'd0);
    repeat (3) @(negedge clk_i);
    chk(bc_valid_o == 4'hF && bc_data_o == 32'hA5, "R8 hold without ready", 32'(bc_valid_o), 32'hF);
    bc_ready_i = 4'b0001;
    @(negedge clk_i);
    bc_ready_i = '0;
    chk(bc_valid_o == 4'b1110, "R8 single port release", 32'(bc_valid_o), 32'hE);
    chk(bc_addr_o == 4'd5 && bc_data_o == 32'hA5, "R8 message stable", bc_data_o, 32'hA5);
    chk(req_ready_o == 1'b0, "R9 stall until all drained", 32'(req_ready_o), 32'd0);
    @(negedge clk_i);
    chk(bc_valid_o == 4'b1110, "R8 other ports unaffected", 32'(bc_valid_o), 32'hE);
    bc_ready_i = 4'b1111;
    @(negedge clk_i);
    bc_ready_i = '0;
    chk(bc_valid_o == '0, "R8 all drained", 32'(bc_valid_o), 32'd0);
    chk(req_ready_o == 1'b1, "R9 resume after drain", 32'(req_ready_o), 32'd1);
    chk(rsp_valid_o && rsp_data_o == 32'd0 && rsp_src_o == 4'd2, "R9 held response", rsp_data_o, 32'd0);
    @(negedge clk_i);
    chk(bc_valid_o == 4'hF, "R7 second broadcast on all ports", 32'(bc_valid_o), 32'hF);
    chk(bc_addr_o == 4'd6 && bc_data_o == 32'd1, "R7 second broadcast message", bc_data_o, 32'd1);

    // R7 bank holds broadcast value
    issue(3'd0, 4'd5, 32'd0, 4'd3);
    @(negedge clk_i);
    chk(rsp_valid_o && rsp_data_o == 32'hA5, "R7 bank written", rsp_data_o, 32'hA5);
    bc_ready_i = '1;
    repeat (2) @(negedge clk_i);
    chk(bc_valid_o == '0 && req_ready_o, "R9 idle ready", 32'(bc_valid_o), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule